// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static RAM array from a single clock domain. It takes two digital comparator flags from the supply monitor. One says the supply is above the write-protect trip level. The other says the supply is above the lower level at which the array changes over between main power and battery. Both flags are synchronized inside the block. From them it gates the host's chip-enable and write-enable on their way to the array, decides when the array's data outputs may drive, selects the supply source and keeps a one-time battery-enable latch.

Parts leave the factory with the battery disconnected. The latch arms the battery path on the first valid power-up and holds that state until the block is reset. Each time the supply returns above the trip level, the block holds the array locked for a recovery window of `REC_CYCLES` clocks. At the default clock this window is one eighth of a second. If the supply dips again during the window, the count starts over. A one-hot status word reports the current phase of the sequence.

Which supply-tolerance variant is in use is set outside the block, by the choice of comparator whose flag is wired to `trip_ok_raw`.

Top module: `pfw_sequencer`

## Requirements
- R1: Whenever `status` is not NORMAL, `ram_ce_n` and `ram_we_n` are held at 1 and `dq_drive` at 0, whatever the three host control inputs are.
- R2: In NORMAL, `ram_ce_n` follows `host_ce_n` and `ram_we_n` follows `host_we_n` in the same cycle.
- R3: `dq_drive` is 1 only in NORMAL with `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1. An active write-enable therefore turns the outputs off.
- R4: Each comparator flag passes through a `SYNC_STAGES`-flop synchronizer (default 2). A change at a raw input first affects the outputs after that many rising clock edges.
- R5: After reset, `bat_armed` is 0. It becomes 1 one edge after the synchronized trip flag is first seen at 1, and it then stays 1 whatever the supply does, until the next reset.
- R6: `bat_sel` (1 = battery) is 1 exactly when `bat_armed` is 1 and the synchronized switchover flag is 0. It is never 1 while unarmed.
- R7: NORMAL is entered on the `SYNC_STAGES+REC_CYCLES`-th rising edge after `trip_ok_raw` rises. Before that edge the state is RECOVERING, or SEALED while not yet armed.
- R8: If the trip flag falls during the recovery window, the count is discarded. A later rise again needs the full `SYNC_STAGES+REC_CYCLES` edges.
- R9: `status` is one-hot with bit 0 SEALED, bit 1 NORMAL, bit 2 PROTECTED, bit 3 ON_BATTERY and bit 4 RECOVERING. The states are tested in this order: SEALED if unarmed; otherwise ON_BATTERY if the switchover flag is 0; otherwise PROTECTED if the trip flag is 0; otherwise RECOVERING until the count completes; otherwise NORMAL.
- R10: While `rst_n` is 0, `status` is SEALED (5'b00001), `bat_sel` and `bat_armed` are 0, `ram_ce_n` and `ram_we_n` are 1 and `dq_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_ok_raw | input | 1 | Supply above write-protect trip level (asynchronous) |
| swover_ok_raw | input | 1 | Supply above battery changeover level (asynchronous) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| ram_ce_n | output | 1 | Gated chip enable to the array |
| ram_we_n | output | 1 | Gated write enable to the array |
| dq_drive | output | 1 | 1 lets the array's data outputs drive |
| bat_sel | output | 1 | 1 selects the battery, 0 the main supply |
| bat_armed | output | 1 | Battery-enable latch |
| status | output | 5 | One-hot phase of the sequence |

## Verification
The assertions assume that the two comparator flags are consistent with each other: the trip flag is never 1 while the changeover flag is 0, since the trip level sits above the changeover level. They also assume that `REC_CYCLES` is at least 1. The stimulus respects the ordering of the two flags. It raises the changeover flag before the trip flag on the way up and drops the trip flag first on the way down. It holds each flag long enough for its synchronizer to settle. Host control changes are made away from clock edges, while the block is held in one state.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
   // Positions of the one-hot status bits.
   localparam int ST_W          = 5;
   localparam int IDX_SEALED    = 0;
   localparam int IDX_NORMAL    = 1;
   localparam int IDX_PROTECTED = 2;
   localparam int IDX_BATTERY   = 3;
   localparam int IDX_RECOVER   = 4;

   typedef enum logic [2:0] {
      PH_SEALED,
      PH_NORMAL,
      PH_PROTECTED,
      PH_BATTERY,
      PH_RECOVER
   } pfw_phase_e;

   function automatic logic [ST_W-1:0] phase_onehot(input pfw_phase_e ph);
      logic [ST_W-1:0] v;
      v = '0;
      unique case (ph)
         PH_SEALED:    v[IDX_SEALED]    = 1'b1;
         PH_NORMAL:    v[IDX_NORMAL]    = 1'b1;
         PH_PROTECTED: v[IDX_PROTECTED] = 1'b1;
         PH_BATTERY:   v[IDX_BATTERY]   = 1'b1;
         default:      v[IDX_RECOVER]   = 1'b1;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pfw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfw_seal_latch.sv
module pfw_seal_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_s,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (trip_s) armed <= 1'b1;
   end
endmodule

// File: rtl/pfw_recovery_timer.sv
module pfw_recovery_timer #(
   parameter int unsigned COUNT = 12_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LIMIT = CW'(COUNT);

   if (COUNT < 1) begin : g_bad_count
      $error("pfw_recovery_timer: COUNT must be at least 1");
   end

   logic [CW-1:0] cnt;

   // Cleared whenever the supply is below trip; saturates at LIMIT.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);
endmodule

// File: rtl/pfw_access_gate.sv
module pfw_access_gate (
   input  logic open,
   input  logic host_ce_n,
   input  logic host_we_n,
   input  logic host_oe_n,
   output logic ram_ce_n,
   output logic ram_we_n,
   output logic dq_drive
);
   always_comb begin
      ram_ce_n = open ? host_ce_n : 1'b1;
      ram_we_n = open ? host_we_n : 1'b1;
      dq_drive = open & ~host_ce_n & ~host_oe_n & host_we_n;
   end
endmodule

// File: rtl/pfw_sequencer.sv
module pfw_sequencer
   import pfw_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned REC_CYCLES  = CLK_HZ / 8,
   parameter int          SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trip_ok_raw,
   input  logic            swover_ok_raw,
   input  logic            host_ce_n,
   input  logic            host_we_n,
   input  logic            host_oe_n,
   output logic            ram_ce_n,
   output logic            ram_we_n,
   output logic            dq_drive,
   output logic            bat_sel,
   output logic            bat_armed,
   output logic [ST_W-1:0] status
);
   if (REC_CYCLES < 1) begin : g_bad_rec
      $error("pfw_sequencer: REC_CYCLES must be at least 1");
   end

   logic trip_s;
   logic swo_s;
   logic rec_done;
   pfw_phase_e phase;

   pfw_sync #(.STAGES(SYNC_STAGES)) u_sync_trip (
      .clk(clk), .rst_n(rst_n), .d(trip_ok_raw), .q(trip_s));

   pfw_sync #(.STAGES(SYNC_STAGES)) u_sync_swo (
      .clk(clk), .rst_n(rst_n), .d(swover_ok_raw), .q(swo_s));

   pfw_seal_latch u_seal (
      .clk(clk), .rst_n(rst_n), .trip_s(trip_s), .armed(bat_armed));

   pfw_recovery_timer #(.COUNT(REC_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(trip_s), .done(rec_done));

   // Phase decode, combinational from registered state.
   always_comb begin
      if (!bat_armed)     phase = PH_SEALED;
      else if (!swo_s)    phase = PH_BATTERY;
      else if (!trip_s)   phase = PH_PROTECTED;
      else if (!rec_done) phase = PH_RECOVER;
      else                phase = PH_NORMAL;
   end

   assign status  = phase_onehot(phase);
   assign bat_sel = bat_armed & ~swo_s;

   pfw_access_gate u_gate (
      .open     (phase == PH_NORMAL),
      .host_ce_n(host_ce_n),
      .host_we_n(host_we_n),
      .host_oe_n(host_oe_n),
      .ram_ce_n (ram_ce_n),
      .ram_we_n (ram_we_n),
      .dq_drive (dq_drive));
endmodule

// File: rtl/pfw_sequencer_chk.sv
module pfw_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       trip_s,
   input logic       host_ce_n,
   input logic       host_we_n,
   input logic       host_oe_n,
   input logic       ram_ce_n,
   input logic       ram_we_n,
   input logic       dq_drive,
   input logic       bat_sel,
   input logic       bat_armed,
   input logic [4:0] status
);
   a_r1_locked_when_not_normal: assert property (@(posedge clk) disable iff (!rst_n)
      !status[1] |-> (ram_ce_n && ram_we_n && !dq_drive));

   a_r2_pass_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> (ram_ce_n == host_ce_n && ram_we_n == host_we_n));

   a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive |-> (!host_ce_n && !host_oe_n && host_we_n));

   a_r5_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bat_armed |=> bat_armed);

   a_r5_arms_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
      trip_s |=> bat_armed);

   a_r6_no_battery_unsealed: assert property (@(posedge clk) disable iff (!rst_n)
      bat_sel |-> bat_armed);

   a_r7_no_direct_normal: assert property (@(posedge clk) disable iff (!rst_n)
      !trip_s |=> !status[1]);

   a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status) == 1);
endmodule

bind pfw_sequencer pfw_sequencer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .trip_s(trip_s),
   .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
   .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .dq_drive(dq_drive),
   .bat_sel(bat_sel), .bat_armed(bat_armed), .status(status));

// File: tb/tb_pfw_sequencer.sv
`timescale 1ns/100ps
module tb_pfw_sequencer;
   localparam int REC  = 20;
   localparam int SYNC = 2;
   localparam logic [4:0] S_SEALED = 5'b00001, S_NORMAL = 5'b00010,
                          S_PROT = 5'b00100, S_BATT = 5'b01000, S_REC = 5'b10000;

   logic clk = 1'b0, rst_n = 1'b0, trip = 1'b0, swo = 1'b0;
   logic hce = 1'b1, hwe = 1'b1, hoe = 1'b1;
   logic ram_ce_n, ram_we_n, dq_drive, bat_sel, bat_armed;
   logic [4:0] status;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   pfw_sequencer #(.CLK_HZ(160), .REC_CYCLES(REC), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .trip_ok_raw(trip), .swover_ok_raw(swo),
      .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
      .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .dq_drive(dq_drive),
      .bat_sel(bat_sel), .bat_armed(bat_armed), .status(status));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // Sweep all host control combinations; open selects the expected gating.
   task automatic sweep(string req, bit open);
      for (int i = 0; i < 8; i++) begin
         logic [2:0] e;
         hce = i[0]; hwe = i[1]; hoe = i[2];
         #0.2;
         if (open) e = {i[0], i[1], ~i[0] & ~i[2] & i[1]};
         else      e = 3'b110;
         chk(req, {ram_ce_n, ram_we_n, dq_drive}, e);
      end
      hce = 1'b1; hwe = 1'b1; hoe = 1'b1;
      #0.2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R10 reset state
      tick(3);
      chk("R10 status", status, S_SEALED);
      chk("R10 bat", {bat_sel, bat_armed}, 0);
      chk("R10 gate", {ram_ce_n, ram_we_n, dq_drive}, 3'b110);
      rst_n = 1'b1;
      // changeover flag up while unarmed
      swo = 1'b1;
      tick(4);
      chk("R6 unarmed no battery", bat_sel, 0);
      chk("R9 sealed", status, S_SEALED);
      sweep("R1 sealed", 1'b0);
      // first power-up
      trip = 1'b1;
      tick(1);
      chk("R4 one edge", bat_armed, 0);
      tick(1);
      chk("R5 not yet armed", bat_armed, 0);
      tick(1);
      chk("R5 armed", bat_armed, 1);
      chk("R9 recovering", status, S_REC);
      tick(SYNC + REC - 4);
      chk("R7 last recovering", status, S_REC);
      sweep("R1 recovering", 1'b0);
      tick(1);
      chk("R7 normal", status, S_NORMAL);
      sweep("R2 R3 normal", 1'b1);
      // supply drops below trip
      trip = 1'b0;
      tick(1);
      chk("R4 still normal", status, S_NORMAL);
      tick(1);
      chk("R9 protected", status, S_PROT);
      chk("R6 main", bat_sel, 0);
      sweep("R1 protected", 1'b0);
      // below changeover
      swo = 1'b0;
      tick(2);
      chk("R9 on battery", status, S_BATT);
      chk("R6 battery", bat_sel, 1);
      chk("R5 sticky", bat_armed, 1);
      sweep("R1 battery", 1'b0);
      swo = 1'b1;
      tick(2);
      chk("R6 back to main", {bat_sel, status}, {1'b0, S_PROT});
      // interrupted recovery
      trip = 1'b1;
      tick(12);
      chk("R8 mid recovery", status, S_REC);
      trip = 1'b0;
      tick(3);
      chk("R8 dropped", status, S_PROT);
      trip = 1'b1;
      tick(SYNC + REC - 1);
      chk("R8 restarted", status, S_REC);
      tick(1);
      chk("R8 normal again", status, S_NORMAL);
      // reset clears the latch
      rst_n = 1'b0;
      #0.5;
      chk("R10 rerun status", status, S_SEALED);
      chk("R5 cleared by reset", bat_armed, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule